// File: doc/BRIEF.md
# UART with XON/XOFF Flow Control

This block is a full-duplex asynchronous serial port with one transmit line and one receive line and no hardware handshake pins. Frames carry eight data bits, least significant first. A start bit of 0 opens each frame and the line idles high. Static configuration inputs set the following:

- the baud divisor
- whether a parity bit is present
- even or odd parity
- one or two stop bits

The user side is byte-wide, with a valid/ready handshake in each direction. Each received byte comes with parity-error and framing-error flags.

When in-band flow control is switched on, the block handles two control characters itself:

- A received XOFF (0x13) stops new characters from being sent. A received XON (0x11) lets them go again. Neither character reaches the receive output.
- The block also watches its small receive buffer. When the buffer is nearly full it sends XOFF to the far end. When the buffer has drained empty it sends XON.

Top module: `sflow_uart`

## Requirements
- R1: The line `txd` is high while idle, and `tx_ready` is high only then. A byte accepted on `tx_valid && tx_ready` starts its start bit (0) on the next cycle. The start bit is followed by the 8 data bits LSB first, then the optional parity bit, then the stop bit(s) at 1.
- R2: Every bit lasts 16*(`baud_div`+1) clock cycles.
- R3: With `par_en`=1, a parity bit follows bit 7. When `par_odd`=0 it makes the count of ones in data plus parity even; when `par_odd`=1 it makes that count odd. With `par_en`=0 no parity bit is sent.
- R4: With `two_stop`=1 the transmitter holds the line high for two bit times and only then becomes ready again. With `two_stop`=0 it holds for one bit time.
- R5: Received bytes are queued in a buffer of DEPTH (4) entries. The head is shown on `rx_data` with `rx_valid` and is held until `rx_ready` removes it.
- R6: With `par_en`=1, a received parity bit that does not match the configured sense sets `rx_par_err` for that byte.
- R7: A first stop bit that samples low sets `rx_frm_err` for that byte. Any second stop bit is not checked.
- R8: Each received bit is decided by the majority of three samples taken at 16x rate around the bit center. A disturbance that corrupts one sample does not change the byte.
- R9: With `flow_en`=1:
  - a received 0x13 holds `tx_ready` low and starts no new character;
  - a received 0x11 lets transmission resume;
  - neither character is queued.
  With `flow_en`=0 both are ordinary data.
- R10: A character already being shifted out when XOFF is received is completed intact.
- R11: With `flow_en`=1, the block sends 0x13 once when the buffer reaches DEPTH-1 entries. It sends 0x11 once the buffer is empty again. These control characters take precedence over user data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | 16x tick every baud_div+1 clocks |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| flow_en | input | 1 | Enable XON/XOFF handling |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter will take `tx_data` this cycle |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | `rx_data` holds a byte |
| rx_ready | input | 1 | Consumer removes the head byte |
| rx_par_err | output | 1 | Parity error for `rx_data` |
| rx_frm_err | output | 1 | Framing error for `rx_data` |

## Verification
Some rules can be checked at every clock edge, and the assertions cover these:
- the line is high whenever the transmitter offers ready;
- a start bit follows acceptance;
- a paused transmitter never offers ready;
- the receive head stays put until it is taken;
- the buffer count never exceeds its depth.

Other behaviour spans whole frames, and only the bench scenarios can show it. This covers bit timing at two divisors, parity sense, stop-bit length, the receive error flags, majority voting against a glitch, and the swallowing of control characters. It also covers a character completing across an XOFF and the buffer-driven XOFF/XON exchange.

// File: rtl/sflow_uart.sv
module sflow_uart #(
  parameter int DIV_W = 16,
  parameter int DEPTH = 4,
  parameter logic [7:0] XON  = 8'h11,
  parameter logic [7:0] XOFF = 8'h13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             two_stop,
  input  logic             flow_en,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_par_err,
  output logic             rx_frm_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DIV_W-1:0] div_q;
  wire tick = (div_q >= baud_div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;

  logic [CW-1:0] cnt_q;
  logic          paused_q, xoff_sent_q;

  // ---------------- transmitter ----------------
  logic        tx_busy;
  logic [11:0] tx_sh, tx_frame;
  logic [3:0]  tx_bits, tx_sub;

  wire want_off = flow_en && !xoff_sent_q && (cnt_q >= CW'(DEPTH - 1));
  wire want_on  = flow_en &&  xoff_sent_q && (cnt_q == '0);
  wire ctl_go   = !tx_busy && (want_off || want_on);
  assign tx_ready = !tx_busy && !want_off && !want_on && !(flow_en && paused_q);
  wire tx_take  = tx_valid && tx_ready;
  wire [7:0] tx_byte = ctl_go ? (want_off ? XOFF : XON) : tx_data;

  always_comb begin
    tx_frame = {3'b111, tx_byte, 1'b0};
    if (par_en) tx_frame[9] = ^tx_byte ^ par_odd;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_bits <= '0;
      tx_sub  <= '0;
    end else if (tx_busy) begin
      if (tick) begin
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == 4'd15) begin
          tx_sh   <= {1'b1, tx_sh[11:1]};
          tx_bits <= tx_bits - 1'b1;
          if (tx_bits == 4'd1) tx_busy <= 1'b0;
        end
      end
    end else if (ctl_go || tx_take) begin
      tx_busy <= 1'b1;
      tx_sh   <= tx_frame;
      tx_sub  <= '0;
      tx_bits <= 4'd10 + {3'b0, par_en} + {3'b0, two_stop};
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        xoff_sent_q <= 1'b0;
    else if (!flow_en) xoff_sent_q <= 1'b0;
    else if (ctl_go)   xoff_sent_q <= want_off;

  // ---------------- receiver ----------------
  logic [1:0] rx_sync;
  logic       rx_busy, rx_par;
  logic [3:0] rx_sub, rx_idx;
  logic [2:0] rx_smp;
  logic [7:0] rx_sh;

  wire rxs      = rx_sync[1];
  wire maj      = (rx_smp[0] & rx_smp[1]) | (rx_smp[0] & rx_smp[2]) | (rx_smp[1] & rx_smp[2]);
  wire last_bit = (rx_idx == (par_en ? 4'd10 : 4'd9));
  wire bit_end  = rx_busy && tick && (rx_sub == 4'd15);
  wire rx_done  = bit_end && last_bit;
  wire rx_perr  = par_en && (rx_par != (^rx_sh ^ par_odd));
  wire rx_ferr  = !maj;
  wire is_ctl   = flow_en && !rx_perr && !rx_ferr && (rx_sh == XON || rx_sh == XOFF);
  wire push     = rx_done && !is_ctl && (cnt_q != CW'(DEPTH));
  wire pop      = rx_ready && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_sub  <= '0;
      rx_idx  <= '0;
      rx_smp  <= '1;
      rx_sh   <= '0;
      rx_par  <= 1'b0;
    end else if (!rx_busy) begin
      if (tick && !rxs) begin
        rx_busy <= 1'b1;
        rx_sub  <= 4'd1;
        rx_idx  <= '0;
      end
    end else if (tick) begin
      rx_sub <= rx_sub + 1'b1;
      if (rx_sub inside {4'd7, 4'd8, 4'd9}) rx_smp <= {rx_smp[1:0], rxs};
      if (rx_sub == 4'd15) begin
        rx_idx <= rx_idx + 1'b1;
        if (rx_idx == 4'd0 && maj)             rx_busy <= 1'b0;
        else if (rx_idx >= 4'd1 && rx_idx <= 4'd8) rx_sh <= {maj, rx_sh[7:1]};
        else if (par_en && rx_idx == 4'd9)     rx_par <= maj;
        if (last_bit) rx_busy <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  paused_q <= 1'b0;
    else if (!flow_en)           paused_q <= 1'b0;
    else if (rx_done && is_ctl)  paused_q <= (rx_sh == XOFF);

  // ---------------- receive buffer ----------------
  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;

  always_ff @(posedge clk)
    if (push) mem[wr_q] <= {rx_ferr, rx_perr, rx_sh};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end

  assign rx_valid = (cnt_q != '0);
  assign {rx_frm_err, rx_par_err, rx_data} = mem[rd_q];
endmodule

// File: rtl/sflow_uart_chk.sv
module sflow_uart_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          txd,
  input logic          flow_en,
  input logic          paused,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [7:0]    rx_data,
  input logic [CW-1:0] cnt
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  assert_start_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !txd);

  assert_hold_when_paused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && paused) |-> !tx_ready);

  assert_head_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

bind sflow_uart sflow_uart_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .flow_en(flow_en), .paused(paused_q), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .cnt(cnt_q)
);

// File: tb/sflow_uart_tb.sv
`timescale 1ns/1ps
module sflow_uart_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic        par_en = 0, par_odd = 0, two_stop = 0, flow_en = 0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 0;
  logic        tx_ready, txd;
  logic        rxd = 1'b1;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_par_err, rx_frm_err;
  logic        rx_ready = 0;

  int tests = 0, fails = 0;
  logic       g_start, g_par, g_s1, g_s2, g_rdy2;
  logic [7:0] g_data;

  always #2.5 clk = ~clk;

  sflow_uart u_dut (.*);

  function automatic int bp();
    return 16 * (int'(baud_div) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic get_char();
    @(negedge txd);
    repeat (bp() / 2) @(negedge clk);
    g_start = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (bp()) @(negedge clk);
      g_data[i] = txd;
    end
    g_par = 1'b1;
    if (par_en) begin
      repeat (bp()) @(negedge clk);
      g_par = txd;
    end
    repeat (bp()) @(negedge clk);
    g_s1 = txd;
    repeat (bp()) @(negedge clk);
    g_s2 = txd;
    g_rdy2 = tx_ready;
  endtask

  task automatic tx_put(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_one(input logic [7:0] d);
    fork
      tx_put(d);
      get_char();
    join
  endtask

  task automatic rx_drive(input logic [7:0] d, input bit bad_par = 0, input bit stop = 1, input int glitch = -1);
    logic p;
    p = ^d ^ par_odd ^ bad_par;
    @(negedge clk);
    rxd = 1'b0;
    repeat (bp()) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      if (i == glitch) begin
        repeat (bp() / 2) @(negedge clk);
        rxd = ~d[i];
        repeat (2) @(negedge clk);
        rxd = d[i];
        repeat (bp() - bp() / 2 - 2) @(negedge clk);
      end else begin
        repeat (bp()) @(negedge clk);
      end
    end
    if (par_en) begin
      rxd = p;
      repeat (bp()) @(negedge clk);
    end
    rxd = stop;
    repeat (bp()) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic pop_check(input logic [7:0] d, input bit pe, input bit fe, input string req);
    @(negedge clk);
    check(rx_valid === 1'b1, req, "rx_valid", rx_valid, 1);
    check(rx_data === d, req, "rx_data", rx_data, d);
    check(rx_par_err === pe, req, "rx_par_err", rx_par_err, pe);
    check(rx_frm_err === fe, req, "rx_frm_err", rx_frm_err, fe);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(txd === 1'b1, "R1", "idle txd", txd, 1);
    check(tx_ready === 1'b1, "R1", "idle tx_ready", tx_ready, 1);
    check(rx_valid === 1'b0, "R5", "empty rx_valid", rx_valid, 0);
  endtask

  task automatic t_tx_basic();
    tx_one(8'hA5);
    check(g_start === 1'b0, "R1", "start bit", g_start, 0);
    check(g_data === 8'hA5, "R1", "data LSB first", g_data, 8'hA5);
    check(g_s1 === 1'b1, "R1", "stop bit", g_s1, 1);
    check(g_rdy2 === 1'b1, "R4", "ready after one stop", g_rdy2, 1);
    baud_div = 16'd2;
    tx_one(8'h3C);
    check(g_data === 8'h3C, "R2", "data at divisor 2", g_data, 8'h3C);
    check(g_s1 === 1'b1, "R2", "stop at divisor 2", g_s1, 1);
    baud_div = 16'd1;
  endtask

  task automatic t_tx_parity();
    par_en = 1; par_odd = 0;
    tx_one(8'h07);
    check(g_par === 1'b1, "R3", "even parity of 0x07", g_par, 1);
    check(g_s1 === 1'b1, "R3", "stop after parity", g_s1, 1);
    par_odd = 1;
    tx_one(8'h07);
    check(g_par === 1'b0, "R3", "odd parity of 0x07", g_par, 0);
    tx_one(8'h00);
    check(g_par === 1'b1, "R3", "odd parity of 0x00", g_par, 1);
    par_en = 0; par_odd = 0;
  endtask

  task automatic t_stop_bits();
    two_stop = 1;
    tx_one(8'h81);
    check(g_data === 8'h81, "R4", "data with two stops", g_data, 8'h81);
    check(g_s2 === 1'b1, "R4", "second stop high", g_s2, 1);
    check(g_rdy2 === 1'b0, "R4", "busy during second stop", g_rdy2, 0);
    two_stop = 0;
  endtask

  task automatic t_rx_basic();
    rx_drive(8'h5A);
    repeat (bp() / 2) @(negedge clk);
    rx_drive(8'hC1);
    repeat (bp() / 2) @(negedge clk);
    pop_check(8'h5A, 0, 0, "R5");
    pop_check(8'hC1, 0, 0, "R5");
    @(negedge clk);
    check(rx_valid === 1'b0, "R5", "drained", rx_valid, 0);
  endtask

  task automatic t_rx_errors();
    par_en = 1; par_odd = 0;
    rx_drive(8'h36, 1);
    repeat (bp() / 2) @(negedge clk);
    pop_check(8'h36, 1, 0, "R6");
    rx_drive(8'h36, 0);
    repeat (bp() / 2) @(negedge clk);
    pop_check(8'h36, 0, 0, "R6");
    par_en = 0;
    rx_drive(8'h9E, 0, 0);
    repeat (bp()) @(negedge clk);
    pop_check(8'h9E, 0, 1, "R7");
  endtask

  task automatic t_glitch();
    rx_drive(8'hFF, 0, 1, 3);
    repeat (bp() / 2) @(negedge clk);
    pop_check(8'hFF, 0, 0, "R8");
    rx_drive(8'h00, 0, 1, 5);
    repeat (bp() / 2) @(negedge clk);
    pop_check(8'h00, 0, 0, "R8");
  endtask

  task automatic t_noflow();
    flow_en = 0;
    rx_drive(8'h13);
    repeat (bp() / 2) @(negedge clk);
    pop_check(8'h13, 0, 0, "R9");
    @(negedge clk);
    check(tx_ready === 1'b1, "R9", "no pause when disabled", tx_ready, 1);
  endtask

  task automatic hold_and_resume(input logic [7:0] d, input string req);
    bit low_seen = 0;
    @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    repeat (3 * bp()) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_ready !== 1'b0) low_seen = 1;
    end
    check(!low_seen, req, "held while paused", low_seen, 0);
    fork
      rx_drive(8'h11);
      get_char();
      begin
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
      end
    join
    check(g_data === d, req, "sent after XON", g_data, d);
    check(rx_valid === 1'b0, req, "XON not queued", rx_valid, 0);
  endtask

  task automatic t_pause();
    flow_en = 1;
    rx_drive(8'h13);
    repeat (bp()) @(negedge clk);
    check(rx_valid === 1'b0, "R9", "XOFF not queued", rx_valid, 0);
    check(tx_ready === 1'b0, "R9", "paused ready", tx_ready, 0);
    hold_and_resume(8'h3C, "R9");
  endtask

  task automatic t_midchar();
    fork
      rx_drive(8'h13);
      begin
        repeat (4 * bp()) @(negedge clk);
        tx_put(8'hC3);
      end
      get_char();
    join
    check(g_data === 8'hC3, "R10", "char completed", g_data, 8'hC3);
    check(g_s1 === 1'b1, "R10", "stop of completed char", g_s1, 1);
    hold_and_resume(8'h77, "R10");
  endtask

  task automatic t_fill();
    rx_drive(8'h01);
    rx_drive(8'h02);
    fork
      rx_drive(8'h03);
      get_char();
    join
    check(g_data === 8'h13, "R11", "XOFF sent at threshold", g_data, 8'h13);
    fork
      get_char();
      begin
        pop_check(8'h01, 0, 0, "R11");
        pop_check(8'h02, 0, 0, "R11");
        pop_check(8'h03, 0, 0, "R11");
      end
    join
    check(g_data === 8'h11, "R11", "XON sent when empty", g_data, 8'h11);
    flow_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_parity();
    t_stop_bits();
    t_rx_basic();
    t_rx_errors();
    t_glitch();
    t_noflow();
    t_pause();
    t_midchar();
    t_fill();
    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule